// File: doc/BRIEF.md
# PHY Test-Port Register Slave

This block is the receiving end of a narrow configuration port that a host uses to program registers inside a physical-layer macro. The host drives four signals by software: a slow test clock, a clear, an enable and an 8-bit data bus. One bus carries both the register address and the register data. The block works out which of the two is on the bus from the direction of the test-clock transition and from the level of enable at that moment. It keeps a bank of 8-bit registers and always drives the contents of the selected register onto an 8-bit read-back bus.

The test signals arrive without any timing relationship to the block's own clock. The block passes them through a synchroniser and finds test-clock transitions by comparing successive synchronised samples. A falling transition while enable is high loads a new address. A rising transition while enable is low stores the bus value at the current address. The other two combinations change nothing. While clear is high, the address and every register go to zero. Only addresses 0x00 to 0x97 hold state.

Top module: `tport_slave`

## Requirements
- R1: A falling test-clock transition seen while enable is high loads the data-in byte into the address pointer.
- R2: A rising test-clock transition seen while enable is low stores the data-in byte into the register at the address pointer.
- R3: Data-out is registered and presents the register chosen by the address pointer. It follows every state change exactly one clock after that change.
- R4: Registers exist at addresses 0x00 through 0x97 only. A store to an address of 0x98 or above changes nothing, and selecting such an address gives 0x00 on data-out.
- R5: While clear is high, the address pointer and all registers are forced to zero, and data-out then reads 0x00.
- R6: A rising transition with enable high and a falling transition with enable low change neither the address pointer nor any register.
- R7: Test clock, clear, enable and data-in each pass through two synchroniser flops. A pin change first sampled at clock edge t shows on data-out after edge t+3 and not earlier.
- R8: The synchronous reset input clears the address pointer, all registers, the synchroniser and data-out.
- R9: A store leaves the address pointer unchanged, and loading an address leaves register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tst_clk_i | input | 1 | Asynchronous test clock from the host |
| tst_clr_i | input | 1 | Asynchronous clear, active high |
| tst_en_i | input | 1 | Asynchronous enable: high marks an address phase |
| tst_din_i | input | DATA_W (8) | Shared address and data bus |
| tst_dout_o | output | DATA_W (8) | Contents of the selected register |

## Verification
The hardest cases to reach are the two ignored combinations, a rising edge with enable high and a falling edge with enable low, because the host's normal write sequence never produces them. The stimulus builds them deliberately. It raises enable while the test clock is low and then raises the clock with a new byte on the bus. It then drops the clock with enable low and a different byte on the bus. After each step it checks that the previously selected register is still shown on data-out. A behavioural model in the bench delays the pins through a queue and compares data-out on every clock, which also pins down the exact three-cycle latency.

// File: rtl/tport_pkg.sv
package tport_pkg;

  // Kind of event seen on the synchronised test clock
  typedef enum logic [1:0] {
    EV_IDLE = 2'd0,  // no transition
    EV_ADDR = 2'd1,  // falling edge, enable high
    EV_DATA = 2'd2,  // rising edge, enable low
    EV_NOP  = 2'd3   // transition with the other enable level
  } tport_ev_e;

  function automatic tport_ev_e tport_classify(input logic rise,
                                               input logic fall,
                                               input logic en);
    tport_ev_e k;
    k = EV_IDLE;
    if (rise)      k = en ? EV_NOP  : EV_DATA;
    else if (fall) k = en ? EV_ADDR : EV_NOP;
    return k;
  endfunction

endpackage

// File: rtl/tport_sync.sv
module tport_sync #(
  parameter int WIDTH  = 11,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q[0] <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[LAST];

endmodule

// File: rtl/tport_edge.sv
module tport_edge
  import tport_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tclk_s,
  input  logic      en_s,
  output tport_ev_e ev_o
);

  logic tclk_d;
  logic rise;
  logic fall;

  always_ff @(posedge clk) begin
    if (rst) tclk_d <= 1'b0;
    else     tclk_d <= tclk_s;
  end

  assign rise = tclk_s & ~tclk_d;
  assign fall = ~tclk_s & tclk_d;
  assign ev_o = tport_classify(rise, fall, en_s);

  // R6
  edge_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_o == EV_ADDR || ev_o == EV_DATA || ev_o == EV_NOP) |=> (tclk_d != $past(tclk_d)));

endmodule

// File: rtl/tport_regfile.sv
module tport_regfile #(
  parameter int          DATA_W    = 8,
  parameter int          ADDR_W    = 8,
  parameter int unsigned LAST_ADDR = 'h97
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = LAST_ADDR + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              w_in_range;
  logic              r_in_range;

  assign w_in_range = (32'(waddr_i) <= LAST_ADDR);
  assign r_in_range = (32'(raddr_i) <= LAST_ADDR);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i && w_in_range) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             rdata_o <= '0;
    else if (r_in_range) rdata_o <= mem[raddr_i];
    else                 rdata_o <= '0;
  end

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (we_i && !clr_i && w_in_range) |=> (mem[$past(waddr_i)] == $past(wdata_i)));

  // R4
  high_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!r_in_range) |=> (rdata_o == '0));

endmodule

// File: rtl/tport_slave.sv
module tport_slave
  import tport_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int unsigned LAST_ADDR   = 'h97,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tst_clk_i,
  input  logic              tst_clr_i,
  input  logic              tst_en_i,
  input  logic [DATA_W-1:0] tst_din_i,
  output logic [DATA_W-1:0] tst_dout_o
);

  localparam int BUS_W = DATA_W + 3;

  logic [BUS_W-1:0]  pins_s;
  logic              clr_s;
  logic              en_s;
  logic              tclk_s;
  logic [DATA_W-1:0] din_s;
  tport_ev_e         ev;
  logic [DATA_W-1:0] addr_q;

  tport_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({tst_clr_i, tst_en_i, tst_clk_i, tst_din_i}),
    .sync_o  (pins_s)
  );

  assign {clr_s, en_s, tclk_s, din_s} = pins_s;

  tport_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .tclk_s (tclk_s),
    .en_s   (en_s),
    .ev_o   (ev)
  );

  always_ff @(posedge clk) begin
    if (rst || clr_s)       addr_q <= '0;
    else if (ev == EV_ADDR) addr_q <= din_s;
  end

  tport_regfile #(.DATA_W(DATA_W), .ADDR_W(DATA_W), .LAST_ADDR(LAST_ADDR)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr_s),
    .we_i    (ev == EV_DATA),
    .waddr_i (addr_q),
    .wdata_i (din_s),
    .raddr_i (addr_q),
    .rdata_o (tst_dout_o)
  );

  // R1
  addr_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_ADDR && !clr_s) |=> (addr_q == $past(din_s)));

  // R6
  nop_keeps_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_NOP && !clr_s) |=> $stable(addr_q));

  // R9
  data_keeps_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_DATA && !clr_s) |=> $stable(addr_q));

  // R5
  clear_addr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_s |=> (addr_q == '0));

  // R5
  clear_dout_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_s && $past(clr_s)) |=> (tst_dout_o == '0));

endmodule

// File: tb/tport_slave_test.sv
module tport_slave_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tclk = 1'b0;
  logic       tclr = 1'b0;
  logic       ten = 1'b0;
  logic [7:0] tdin = 8'h00;
  logic [7:0] dout;

  int nchecks = 0;
  int nerrs = 0;
  bit armed = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tport_slave uut (
    .clk        (clk),
    .rst        (rst),
    .tst_clk_i  (tclk),
    .tst_clr_i  (tclr),
    .tst_en_i   (ten),
    .tst_din_i  (tdin),
    .tst_dout_o (dout)
  );

  task automatic check(input string req, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nerrs++;
      $display("FAIL %s at %0t: actual=0x%02h expected=0x%02h", req, $time, act, exp);
    end
  endtask

  // Behavioural model: pins delayed through a queue, state in integers
  logic [10:0] hq[$];
  logic [10:0] cur;
  logic [10:0] old;
  int m_addr;
  int m_mem[256];
  int dout_exp;

  always @(posedge clk) begin
    armed = 1;
    if (rst) begin
      hq = {11'd0, 11'd0, 11'd0};
      m_addr = 0;
      foreach (m_mem[i]) m_mem[i] = 0;
      dout_exp = 0;
    end else begin
      hq.push_front({tclr, ten, tclk, tdin});
      dout_exp = (m_addr <= 'h97) ? m_mem[m_addr] : 0;
      cur = hq[2];
      old = hq[3];
      if (cur[10]) begin
        m_addr = 0;
        foreach (m_mem[i]) m_mem[i] = 0;
      end else if (cur[8] && !old[8] && !cur[9]) begin
        if (m_addr <= 'h97) m_mem[m_addr] = int'(cur[7:0]);
      end else if (!cur[8] && old[8] && cur[9]) begin
        m_addr = int'(cur[7:0]);
      end
      void'(hq.pop_back());
    end
  end

  // Every-cycle comparison against the model (R3, R7)
  always @(negedge clk) begin
    if (armed && !done) check("R3/R7 model", int'(dout), dout_exp);
  end

  task automatic step();
    repeat (6) @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    tclk = 1'b1; step();
    tdin = a;    step();
    ten = 1'b1;  step();
    tclk = 1'b0; step();
    ten = 1'b0;  step();
    tdin = d;    step();
    tclk = 1'b1; step();
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [7:0] v);
    tclk = 1'b1; step();
    tdin = a;    step();
    ten = 1'b1;  step();
    tclk = 1'b0; step();
    ten = 1'b0;  step();
    v = dout;
    tdin = v;    step();
    tclk = 1'b1; step();
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    check("R8 reset dout", int'(dout), 0);
    rst = 1'b0;
    step();

    // R2 R3: store then observe the selected register
    write_reg(8'h10, 8'hA5);
    check("R2 store 0x10", int'(dout), 'hA5);
    write_reg(8'h20, 8'h3C);
    check("R3 shows 0x20", int'(dout), 'h3C);

    // R1 R9: address capture selects, leaves contents
    read_reg(8'h10, v);
    check("R1 read 0x10", int'(v), 'hA5);
    read_reg(8'h20, v);
    check("R9 read 0x20 kept", int'(v), 'h3C);

    // R4: top implemented address and beyond
    write_reg(8'h97, 8'hFF);
    read_reg(8'h97, v);
    check("R4 read 0x97", int'(v), 'hFF);
    write_reg(8'h98, 8'h77);
    check("R4 dout at 0x98", int'(dout), 0);
    read_reg(8'h98, v);
    check("R4 read 0x98", int'(v), 0);
    write_reg(8'hFF, 8'h12);
    read_reg(8'h97, v);
    check("R4 0x97 untouched", int'(v), 'hFF);

    // R6: rising edge with enable high, falling edge with enable low
    read_reg(8'h10, v);
    tclk = 1'b0; step();
    ten = 1'b1;  step();
    tdin = 8'h55; step();
    tclk = 1'b1; step();
    check("R6 rise en high no store", int'(dout), 'hA5);
    ten = 1'b0;  step();
    tdin = 8'h20; step();
    tclk = 1'b0; step();
    check("R6 fall en low no addr", int'(dout), 'hA5);
    tdin = 8'hA5; step();
    read_reg(8'h10, v);
    check("R6 0x10 intact", int'(v), 'hA5);

    // R7: latency of a store to data-out
    write_reg(8'h30, 8'h11);
    tclk = 1'b0; step();
    tdin = 8'h22; step();
    tclk = 1'b1;
    @(negedge clk); check("R7 lat1", int'(dout), 'h11);
    @(negedge clk); check("R7 lat2", int'(dout), 'h11);
    @(negedge clk); check("R7 lat3", int'(dout), 'h11);
    @(negedge clk); check("R7 lat4", int'(dout), 'h22);
    step();

    // R5: clear zeroes pointer and registers
    tclr = 1'b1; step();
    check("R5 dout during clear", int'(dout), 0);
    tclr = 1'b0; step();
    read_reg(8'h10, v);
    check("R5 0x10 cleared", int'(v), 0);
    read_reg(8'h97, v);
    check("R5 0x97 cleared", int'(v), 0);

    // R8: reset in mid run
    write_reg(8'h44, 8'h9C);
    check("R8 pre-reset", int'(dout), 'h9C);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 dout after reset", int'(dout), 0);
    rst = 1'b0; step();
    read_reg(8'h44, v);
    check("R8 0x44 cleared", int'(v), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchecks++;
      nerrs++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
    end
  end

endmodule